// File: doc/BRIEF.md
# Bus Byte Lane Steering Unit

This unit connects a 16-bit host data path to a shared bus whose targets can be either 8 or 16 bits wide. The host gives one request at a time: an address, write data, a size (byte or word) and a direction. The unit then runs one or two bus cycles. It places the data on the correct byte lanes and drives a byte-high-enable line. When the target is narrow, it collects the returned bytes into a 16-bit read result. A word request counts as narrow when the addressed target leaves its active-low 16-bit select response high at the end of the address cycle. The unit then splits the word into two byte cycles. The first goes to the even address and carries the low byte. The second goes to the next, odd address and carries the high byte.

Each bus cycle has one address cycle with both strobes idle, then a fixed number of strobe cycles. Any single-byte bus cycle copies its byte onto both lanes. A narrow target therefore always finds the byte on bits 7:0, and a wide target finds it on the lane its address selects. The host side is a valid/ready input. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While the unit is busy the host is back-pressured: `req_ready` stays low until the one-cycle `rsp_valid` done pulse has been given. The done pulse cannot be stalled, and `rsp_rdata` is valid while it is high.

Top module: `bus_lane_steer`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, and `bus_rd_n` and `bus_wr_n` are both 1.
- R2: Every bus cycle has one cycle with both strobes high, followed by `STRB_LEN` cycles with `bus_rd_n` low (read) or `bus_wr_n` low (write). The two strobes are never low together. `bus_addr` and `bus_hi_en` hold steady from the address cycle to the end of the strobe.
- R3: In every bus cycle, `bus_hi_en` equals `bus_addr[0]` OR (the request is a word).
- R4: A byte request carries its byte in `req_wdata[7:0]`. Any single-byte bus cycle drives that byte on both `bus_wdata[7:0]` and `bus_wdata[15:8]`. A word cycle to a 16-bit target drives `req_wdata` unchanged.
- R5: A word request whose target drives `bus_cs16_n` low at the end of the first address cycle completes in one bus cycle.
- R6: A word request whose target leaves `bus_cs16_n` high completes in two bus cycles. The first uses the even address and the low byte. The second uses the even address with bit 0 set and the high byte. `bus_cs16_n` is sampled only in the first address cycle.
- R7: Read byte selection works as follows. A 16-bit target at an odd address gives the byte on `bus_rdata[15:8]`. Every other byte cycle takes `bus_rdata[7:0]`. A word result is {high byte, low byte}. A byte result has bits 15:8 zero.
- R8: For word requests, `req_addr[0]` is ignored and the even address is used.
- R9: `req_ready` is high only while idle. A request offered while busy is not taken. `rsp_valid` is a one-cycle pulse, and `req_ready` is high in the cycle after it.
- R10: Counting the acceptance edge as cycle 0, `rsp_valid` is high in cycle N*(1+STRB_LEN)+1, where N is the number of bus cycles (1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 16 | Write data (byte requests use bits 7:0) |
| req_word | input | 1 | 1 = 16-bit request, 0 = byte request |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Assembled read data, valid with rsp_valid |
| bus_addr | output | ADDR_W | Bus byte address of the current cycle |
| bus_hi_en | output | 1 | Byte-high-enable, active high |
| bus_wdata | output | 16 | Bus write data lanes |
| bus_rdata | input | 16 | Bus read data lanes |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs16_n | input | 1 | Target 16-bit select response, active low |

## Verification
The bench builds the unit with `ADDR_W` = 4 and `STRB_LEN` = 2. With 4 address bits the whole 16-byte target space is small enough to sweep every start address, both request sizes, both directions and both target widths. Each write is then read back, and the bench's byte-level model of the target is compared in full. A strobe of two cycles makes the address-hold and the latency rules visible across a real multi-cycle strobe. During every busy period the bench keeps offering a conflicting write, to show that back-pressure holds.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bls_seq.sv
module bls_seq
  import lane_steer_pkg::*;
#(
  parameter int STRB_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       word_i,
  input  logic       cs16_n,
  output seq_state_t state_o,
  output logic       half_o,
  output logic       split_o,
  output logic       wide_o,
  output logic       cap_o
);
  localparam int CW = $clog2(STRB_LEN + 1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          half_q, split_q, wide_q;
  logic          last_strb;

  assign last_strb = (state_q == ST_STRB) && (cnt_q == CW'(STRB_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      split_q <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            state_q <= ST_ADDR;
            half_q  <= 1'b0;
            split_q <= 1'b0;
            wide_q  <= 1'b0;
          end
        end
        ST_ADDR: begin
          cnt_q   <= '0;
          state_q <= ST_STRB;
          // target width is decided once, in the first address cycle
          if (!half_q) begin
            wide_q  <= ~cs16_n;
            split_q <= word_i & cs16_n;
          end
        end
        ST_STRB: begin
          if (last_strb) begin
            if (split_q && !half_q) begin
              half_q  <= 1'b1;
              state_q <= ST_ADDR;
            end else begin
              state_q <= ST_FIN;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign half_o  = half_q;
  assign split_o = split_q;
  assign wide_o  = wide_q;
  assign cap_o   = last_strb;
endmodule

// File: rtl/bls_lanes.sv
module bls_lanes #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              word_i,
  input  logic              half_i,
  input  logic              split_i,
  input  logic              wide_i,
  input  logic [15:0]       wdata_i,
  input  logic [15:0]       bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              hi_en,
  output logic [15:0]       bus_wdata,
  output logic [7:0]        rd_byte
);
  logic [7:0] wr_byte;

  always_comb begin
    bus_addr = half_i ? {base_addr[ADDR_W-1:1], 1'b1} : base_addr;
    hi_en    = bus_addr[0] | word_i;
    wr_byte  = (word_i && half_i) ? wdata_i[15:8] : wdata_i[7:0];
    if (word_i && !split_i) bus_wdata = wdata_i;
    else                    bus_wdata = {wr_byte, wr_byte};
    rd_byte  = (wide_i && bus_addr[0]) ? bus_rdata[15:8] : bus_rdata[7:0];
  end
endmodule

// File: rtl/bls_gather.sv
module bls_gather (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_i,
  input  logic        word_i,
  input  logic        split_i,
  input  logic        half_i,
  input  logic [15:0] bus_rdata,
  input  logic [7:0]  rd_byte,
  output logic [15:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (cap_i) begin
      if (word_i && !split_i) rdata_o        <= bus_rdata;
      else if (!word_i)       rdata_o        <= {8'h00, rd_byte};
      else if (half_i)        rdata_o[15:8]  <= rd_byte;
      else                    rdata_o[7:0]   <= rd_byte;
    end
  end
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int STRB_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              req_word,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_hi_en,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  input  logic              bus_cs16_n
);
  seq_state_t        state;
  logic              half, split, wide, cap, fire;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic              word_q, write_q;
  logic [7:0]        rd_byte;

  assign req_ready = (state == ST_IDLE);
  assign fire      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (fire) begin
      addr_q  <= req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
      wdata_q <= req_wdata;
      word_q  <= req_word;
      write_q <= req_write;
    end
  end

  bls_seq #(.STRB_LEN(STRB_LEN)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_fire(fire), .word_i(word_q),
    .cs16_n(bus_cs16_n), .state_o(state), .half_o(half),
    .split_o(split), .wide_o(wide), .cap_o(cap)
  );

  bls_lanes #(.ADDR_W(ADDR_W)) lanes_i (
    .base_addr(addr_q), .word_i(word_q), .half_i(half), .split_i(split),
    .wide_i(wide), .wdata_i(wdata_q), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .hi_en(bus_hi_en), .bus_wdata(bus_wdata),
    .rd_byte(rd_byte)
  );

  bls_gather gather_i (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .word_i(word_q),
    .split_i(split), .half_i(half), .bus_rdata(bus_rdata),
    .rd_byte(rd_byte), .rdata_o(rsp_rdata)
  );

  assign rsp_valid = (state == ST_FIN);
  assign bus_rd_n  = !((state == ST_STRB) && !write_q);
  assign bus_wr_n  = !((state == ST_STRB) &&  write_q);
endmodule

// File: rtl/bus_lane_steer_chk.sv
module bus_lane_steer_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_hi_en,
  input logic [15:0]       bus_wdata,
  input logic              bus_rd_n,
  input logic              bus_wr_n
);
  logic strb;
  assign strb = !bus_rd_n || !bus_wr_n;

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |-> $stable(bus_addr) && $stable(bus_hi_en));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb && $past(strb) |-> $stable(bus_addr) && $stable(bus_hi_en));

  assert_odd_hi_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb && bus_addr[0] |-> bus_hi_en);

  assert_dup_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n && bus_addr[0] |-> bus_wdata[15:8] == bus_wdata[7:0]);

  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !strb && !rsp_valid);
endmodule

bind bus_lane_steer bus_lane_steer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .bus_addr(bus_addr), .bus_hi_en(bus_hi_en),
  .bus_wdata(bus_wdata), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
);

// File: tb/bus_lane_steer_tb_top.sv
`timescale 1ns/1ps
module bus_lane_steer_tb_top;
  localparam int AW = 4;
  localparam int SL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          req_word = 1'b0, req_write = 1'b0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_hi_en;
  logic [15:0]   bus_wdata, bus_rdata;
  logic          bus_rd_n, bus_wr_n, bus_cs16_n;
  logic          tgt16 = 1'b1;

  logic [7:0] tmem [16];
  logic [7:0] ref_mem [16];
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  bus_lane_steer #(.ADDR_W(AW), .STRB_LEN(SL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_word(req_word),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_hi_en(bus_hi_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_cs16_n(bus_cs16_n)
  );

  assign bus_cs16_n = ~tgt16;

  // target model: wide targets decode even byte by bit 0, odd byte by hi_en
  always_comb begin
    if (tgt16) bus_rdata = {tmem[{bus_addr[3:1], 1'b1}], tmem[{bus_addr[3:1], 1'b0}]};
    else       bus_rdata = {8'hEE, tmem[bus_addr]};
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) tmem[i] <= 8'(i * 29 + 7);
    end else if (!bus_wr_n) begin
      if (tgt16) begin
        if (!bus_addr[0]) tmem[bus_addr] <= bus_wdata[7:0];
        if (bus_hi_en)    tmem[{bus_addr[3:1], 1'b1}] <= bus_wdata[15:8];
      end else begin
        tmem[bus_addr] <= bus_wdata[7:0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input bit wr, input bit wd, input logic [3:0] a,
                     input logic [15:0] data, output logic [15:0] rd);
    int k, strb_cnt, bhe_err, rdy_err, lane_err, excl_err, ncyc;
    bit fin;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = data;
    chk(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 32'd1);
    @(posedge clk);
    k = 0; strb_cnt = 0; bhe_err = 0; rdy_err = 0; lane_err = 0; excl_err = 0; fin = 0;
    while (!fin && k < 60) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        // conflicting write offered during the busy period
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
        req_addr = a ^ 4'h6; req_wdata = 16'hDEAD;
      end
      if (rsp_valid) begin
        fin = 1;
      end else begin
        if (req_ready) rdy_err++;
        if (!bus_rd_n && !bus_wr_n) excl_err++;
        if (!bus_rd_n || !bus_wr_n) begin
          strb_cnt++;
          if (bus_hi_en != (bus_addr[0] | wd)) bhe_err++;
          if (!bus_wr_n) begin
            if (wd && tgt16) begin
              if (bus_wdata != data) lane_err++;
            end else if (bus_wdata[15:8] != bus_wdata[7:0]) lane_err++;
          end
        end
      end
    end
    req_valid = 1'b0;
    rd = rsp_rdata;
    ncyc = (wd && !tgt16) ? 2 : 1;
    chk(k == ncyc * (1 + SL) + 1, "R10 done latency", 32'(k), 32'(ncyc * (1 + SL) + 1));
    chk(strb_cnt == ncyc * SL, "R5/R6 strobe cycle count", 32'(strb_cnt), 32'(ncyc * SL));
    chk(excl_err == 0, "R2 strobes exclusive", 32'(excl_err), 32'd0);
    chk(bhe_err == 0, "R3 hi_en rule", 32'(bhe_err), 32'd0);
    chk(rdy_err == 0, "R9 ready low while busy", 32'(rdy_err), 32'd0);
    if (wr) chk(lane_err == 0, "R4 write lane placement", 32'(lane_err), 32'd0);
  endtask

  task automatic cmp_mem();
    int bad = 0;
    for (int i = 0; i < 16; i++) if (tmem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, "R4/R6/R8 target bytes after write", 32'(bad), 32'd0);
  endtask

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd, wdat, exp;
    logic [3:0]  ae, ao;
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'(i * 29 + 7);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
    chk(bus_rd_n && bus_wr_n, "R1 reset strobes", {bus_rd_n, bus_wr_n}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && bus_rd_n && bus_wr_n,
        "R1 first cycle after reset", {req_ready, rsp_valid, bus_rd_n, bus_wr_n}, 4'b1011);

    for (int t = 0; t < 2; t++) begin
      for (int w = 0; w < 2; w++) begin
        for (int a = 0; a < 16; a++) begin
          tgt16 = (t == 1);
          ae = {4'(a) >> 1, 1'b0}; ao = ae | 4'h1;
          wdat = 16'((a * 16'h1357) ^ (t ? 16'hA5C3 : 16'h3C5A) ^ (w ? 16'h0F0F : 16'h0));
          txn(1'b1, w[0], 4'(a), wdat, rd);
          if (w == 1) begin
            ref_mem[ae] = wdat[7:0];
            ref_mem[ao] = wdat[15:8];
          end else begin
            ref_mem[a] = wdat[7:0];
          end
          cmp_mem();
          txn(1'b0, w[0], 4'(a), 16'h0, rd);
          exp = (w == 1) ? {ref_mem[ao], ref_mem[ae]} : {8'h00, ref_mem[a]};
          chk(rd == exp, "R7 assembled read data", 32'(rd), 32'(exp));
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule